// File: doc/BRIEF.md
# Banked Register and Stack Address Unit

This unit owns the 128-byte internal data RAM of a small 8-bit controller core and turns every kind of data-memory reference into a RAM, special-function or null access. There are three kinds of reference. The first is a 3-bit working-register operand, resolved through the two bank-select bits that the core's status register supplies. The second is a direct byte address. The third is an indirect byte address given as a pointer value. The lowest 32 bytes hold four banks of eight working registers. Software changes `bank_sel` to switch register context without saving anything.

A second request stream carries stack traffic through an internal 8-bit stack pointer. A push increments the pointer and then writes at the new value. A pop reads at the current value and then decrements the pointer. Direct addresses at 80h and above leave the block on a special-function register port. Indirect pointers in that range are refused. The stack is never allowed to write there.

Both request streams are valid/ready. A request transfers on a clock edge where its valid and ready are both high. The stack stream has priority: `acc_ready` is low in any cycle where `stk_valid` is high. Reads return on a valid/ready response stream. When the response is held (`rsp_valid` high, `rsp_ready` low), both request streams are stalled and the response stays unchanged. The SFR read data must stay constant from the cycle after `sfr_re` until the next `sfr_re`.

Top module: `regbank_stack_unit`

## Requirements
- R1: After reset the stack pointer is 07h, the overflow flag is 0, `rsp_valid` is 0 and no SFR strobe is active.
- R2: A register operation (acc_op 0 = register read, 1 = register write) addresses RAM byte bank_sel*8 + acc_addr[2:0]. `bank_sel` is sampled at the transfer, and the same register number in different banks selects different bytes.
- R3: A direct operation (2 = read, 3 = write) with an address below 80h reaches the same RAM byte as any register or indirect access to that address.
- R4: A direct operation with an address of 80h or above raises `sfr_we` or `sfr_re` in the transfer cycle, with `sfr_addr` and `sfr_wdata` taken from the request. RAM is left untouched. A read response carries `sfr_rdata`.
- R5: An indirect operation (4 = read, 5 = write) below 80h accesses RAM. At 80h or above, a write is dropped, and a read returns 00h with `rsp_err` = 1. Neither case produces an SFR strobe.
- R6: A push (stk_pop = 0) increments the stack pointer and then writes the data at the new pointer value.
- R7: A pop (stk_pop = 1) returns the byte at the current pointer, and the pointer then decrements.
- R8: The pointer wraps modulo 256. A push whose new pointer is 80h or above sets the sticky `sp_ovf` and writes nothing. A pop at a pointer of 80h or above returns 00h with `rsp_err` = 1.
- R9: When both streams are valid, the stack request transfers first and the access request transfers in a later cycle, so its write lands after the push.
- R10: Every read response appears one cycle after its request transfers. It is held stable while `rsp_ready` is low, and no new request transfers until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bank_sel | input | 2 | Active register bank from the status register |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request ready |
| acc_op | input | 3 | Access kind (0..5, see R2, R3, R5) |
| acc_addr | input | 8 | Register number, direct address or pointer value |
| acc_wdata | input | 8 | Write data for access writes |
| stk_valid | input | 1 | Stack request valid |
| stk_ready | output | 1 | Stack request ready |
| stk_pop | input | 1 | 1 = pop, 0 = push |
| stk_wdata | input | 8 | Push data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read data |
| rsp_err | output | 1 | Refused read (returned as zero) |
| sfr_we | output | 1 | SFR write strobe |
| sfr_re | output | 1 | SFR read strobe |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid the cycle after sfr_re |
| sp | output | 8 | Stack pointer |
| sp_ovf | output | 1 | Sticky stack overflow |

## Verification
A write takes effect at its transfer edge. The stack pointer and `sp_ovf` are therefore compared at the falling edge just after that transfer. Read data is due one cycle after the transfer. The driver queues the expected byte and error bit, and a monitor compares them at each falling edge where `rsp_valid` and `rsp_ready` are both high. With back-pressure off, the bench also requires `rsp_valid` at the first falling edge after the read transfers. With back-pressure on, the monitor requires the held response to stay unchanged from one falling edge to the next.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    OP_REG_RD = 3'd0,
    OP_REG_WR = 3'd1,
    OP_DIR_RD = 3'd2,
    OP_DIR_WR = 3'd3,
    OP_IND_RD = 3'd4,
    OP_IND_WR = 3'd5
  } acc_op_e;

  typedef enum logic [1:0] {
    SRC_RAM  = 2'd0,
    SRC_SFR  = 2'd1,
    SRC_ZERO = 2'd2
  } rsp_src_e;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int AW     = 8,
  parameter int RAM_AW = 7,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  logic [2:0]        op,
  input  logic [AW-1:0]     addr,
  input  logic [BANK_W-1:0] bank,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              to_ram,
  output logic              to_sfr,
  output logic              refused,
  output logic              is_rd,
  output logic              is_wr
);

  localparam int PAD_W = RAM_AW - BANK_W - REG_W;

  logic [RAM_AW-1:0] reg_addr;
  logic              high_half;

  assign reg_addr  = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
  assign high_half = addr[AW-1];

  always_comb begin
    ram_addr = addr[RAM_AW-1:0];
    to_ram   = 1'b0;
    to_sfr   = 1'b0;
    refused  = 1'b0;
    is_rd    = 1'b0;
    is_wr    = 1'b0;
    case (acc_op_e'(op))
      OP_REG_RD, OP_REG_WR: begin
        ram_addr = reg_addr;
        to_ram   = 1'b1;
        is_rd    = (acc_op_e'(op) == OP_REG_RD);
        is_wr    = (acc_op_e'(op) == OP_REG_WR);
      end
      OP_DIR_RD, OP_DIR_WR: begin
        to_sfr = high_half;
        to_ram = !high_half;
        is_rd  = (acc_op_e'(op) == OP_DIR_RD);
        is_wr  = (acc_op_e'(op) == OP_DIR_WR);
      end
      OP_IND_RD, OP_IND_WR: begin
        refused = high_half;
        to_ram  = !high_half;
        is_rd   = (acc_op_e'(op) == OP_IND_RD);
        is_wr   = (acc_op_e'(op) == OP_IND_WR);
      end
      default: begin
        ram_addr = addr[RAM_AW-1:0];
      end
    endcase
  end

endmodule

// File: rtl/regbank_sp.sv
module regbank_sp #(
  parameter int             W     = 8,
  parameter logic [W-1:0]   RESET = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  output logic [W-1:0] sp,
  output logic [W-1:0] sp_inc,
  output logic         ovf
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign sp_inc = sp + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= RESET;
      ovf <= 1'b0;
    end else if (push) begin
      sp  <= sp_inc;
      ovf <= ovf | sp_inc[W-1];
    end else if (pop) begin
      sp  <= sp - ONE;
    end
  end

  AST_PUSH_PRE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp == $past(sp) + ONE)) else $error("push did not advance pointer"); // R6

  AST_POP_POST_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (sp == $past(sp) - ONE)) else $error("pop did not retreat pointer"); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf) else $error("overflow flag cleared"); // R8

endmodule

// File: rtl/regbank_ram.sv
module regbank_ram #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/regbank_stack_unit.sv
module regbank_stack_unit
  import regbank_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            AW       = 8,
  parameter int            BANK_W   = 2,
  parameter int            REG_W    = 3,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [2:0]        acc_op,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  input  logic              stk_valid,
  output logic              stk_ready,
  input  logic              stk_pop,
  input  logic [DW-1:0]     stk_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_err,
  output logic              sfr_we,
  output logic              sfr_re,
  output logic [AW-1:0]     sfr_addr,
  output logic [DW-1:0]     sfr_wdata,
  input  logic [DW-1:0]     sfr_rdata,
  output logic [AW-1:0]     sp,
  output logic              sp_ovf
);

  localparam int RAM_AW = AW - 1;

  logic              slot_free;
  logic              stk_fire, acc_fire, push_fire, pop_fire, rd_fire;
  logic [RAM_AW-1:0] dec_addr;
  logic              dec_ram, dec_sfr, dec_bad, dec_rd, dec_wr;
  logic [AW-1:0]     sp_inc;
  logic              push_fits, pop_fits;
  logic              ram_we, ram_re;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0]     ram_wdata, ram_rdata;
  rsp_src_e          src_q;

  // one response slot: stall both request streams while it is held
  assign slot_free = !rsp_valid || rsp_ready;
  assign stk_ready = slot_free;
  assign acc_ready = slot_free && !stk_valid;

  assign stk_fire  = stk_valid && stk_ready;
  assign acc_fire  = acc_valid && acc_ready;
  assign push_fire = stk_fire && !stk_pop;
  assign pop_fire  = stk_fire && stk_pop;
  assign rd_fire   = pop_fire || (acc_fire && dec_rd);

  regbank_decode #(
    .AW(AW), .RAM_AW(RAM_AW), .BANK_W(BANK_W), .REG_W(REG_W)
  ) u_decode (
    .op(acc_op), .addr(acc_addr), .bank(bank_sel),
    .ram_addr(dec_addr), .to_ram(dec_ram), .to_sfr(dec_sfr),
    .refused(dec_bad), .is_rd(dec_rd), .is_wr(dec_wr)
  );

  regbank_sp #(.W(AW), .RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .push(push_fire), .pop(pop_fire),
    .sp(sp), .sp_inc(sp_inc), .ovf(sp_ovf)
  );

  assign push_fits = !sp_inc[AW-1];
  assign pop_fits  = !sp[AW-1];

  // single write port and single read port, stack first
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = dec_addr;
    ram_wdata = acc_wdata;
    if (push_fire) begin
      ram_we    = push_fits;
      ram_waddr = sp_inc[RAM_AW-1:0];
      ram_wdata = stk_wdata;
    end else if (acc_fire && dec_wr && dec_ram) begin
      ram_we = 1'b1;
    end
  end

  always_comb begin
    ram_re    = 1'b0;
    ram_raddr = dec_addr;
    if (pop_fire) begin
      ram_re    = pop_fits;
      ram_raddr = sp[RAM_AW-1:0];
    end else if (acc_fire && dec_rd && dec_ram) begin
      ram_re = 1'b1;
    end
  end

  regbank_ram #(.DW(DW), .AW(RAM_AW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  assign sfr_we    = acc_fire && dec_wr && dec_sfr;
  assign sfr_re    = acc_fire && dec_rd && dec_sfr;
  assign sfr_addr  = acc_addr;
  assign sfr_wdata = acc_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_q     <= SRC_ZERO;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      if (pop_fire)     src_q <= pop_fits ? SRC_RAM : SRC_ZERO;
      else if (dec_sfr) src_q <= SRC_SFR;
      else if (dec_bad) src_q <= SRC_ZERO;
      else              src_q <= SRC_RAM;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM: rsp_data = ram_rdata;
      SRC_SFR: rsp_data = sfr_rdata;
      default: rsp_data = '0;
    endcase
  end
  assign rsp_err = (src_q == SRC_ZERO);

  AST_HIGH_DIRECT_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && dec_sfr) |-> (!ram_we && !ram_re)) else $error("SFR access touched RAM"); // R4

  AST_IND_NO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_addr[AW-1] && (acc_op == 3'd4 || acc_op == 3'd5)) |-> (!sfr_we && !sfr_re && !ram_we))
    else $error("refused pointer reached a port"); // R5

  AST_NO_HIGH_STACK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && sp_inc[AW-1]) |-> !ram_we) else $error("stack wrote above 7Fh"); // R8

  AST_STACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid |-> !acc_fire) else $error("access overtook stack"); // R9

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid) else $error("response not due"); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)))
    else $error("held response changed"); // R10

endmodule

// File: tb/test_regbank_stack_unit.sv
`timescale 1ns/100ps
module test_regbank_stack_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bank_sel = '0;
  logic       acc_valid = 1'b0;
  logic       acc_ready;
  logic [2:0] acc_op = '0;
  logic [7:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic       stk_valid = 1'b0;
  logic       stk_ready;
  logic       stk_pop = 1'b0;
  logic [7:0] stk_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       rsp_err;
  logic       sfr_we, sfr_re;
  logic [7:0] sfr_addr, sfr_wdata;
  logic [7:0] sfr_rdata;
  logic [7:0] sp;
  logic       sp_ovf;

  always #2.5 clk = ~clk;

  regbank_stack_unit i_regbank_stack_unit (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_op(acc_op),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_pop(stk_pop),
    .stk_wdata(stk_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err),
    .sfr_we(sfr_we), .sfr_re(sfr_re), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .sp(sp), .sp_ovf(sp_ovf)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic bp_mode = 1'b0;
  logic [8:0] exp_q[$];
  logic [7:0] mdl [128];
  logic [7:0] exp_sp = 8'h07;

  // SFR side model
  logic [7:0] sfr_q = '0;
  int sfr_wr_cnt = 0;
  int sfr_rd_cnt = 0;
  logic [7:0] sfr_last_a = '0, sfr_last_d = '0;
  assign sfr_rdata = sfr_q;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sfr_re) begin
      sfr_q <= sfr_addr ^ 8'h3C;
      sfr_rd_cnt <= sfr_rd_cnt + 1;
    end
    if (sfr_we) begin
      sfr_wr_cnt <= sfr_wr_cnt + 1;
      sfr_last_a <= sfr_addr;
      sfr_last_d <= sfr_wdata;
    end
  end

  always @(posedge clk) begin
    #2;
    rsp_ready <= bp_mode ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  logic       hold_prev = 1'b0;
  logic [8:0] hold_val = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev)
        check(rsp_valid && {rsp_err, rsp_data} == hold_val, "R10 held response", {rsp_err, rsp_data}, hold_val);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected response", {rsp_err, rsp_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({rsp_err, rsp_data} == e, "R2-R8 read data", {rsp_err, rsp_data}, e);
        end
      end
      hold_prev = rsp_valid && !rsp_ready;
      hold_val  = {rsp_err, rsp_data};
    end
  end

  task automatic acc_go(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d, input logic [1:0] b);
    @(negedge clk);
    acc_valid = 1'b1; acc_op = op; acc_addr = a; acc_wdata = d; bank_sel = b;
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 acc_valid = 1'b0;
  endtask

  task automatic stk_go(input logic pop, input logic [7:0] d);
    @(negedge clk);
    stk_valid = 1'b1; stk_pop = pop; stk_wdata = d;
    #1;
    while (!stk_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 stk_valid = 1'b0;
  endtask

  task automatic due_check();
    if (!bp_mode) begin
      @(negedge clk);
      check(rsp_valid === 1'b1, "R10 one-cycle latency", rsp_valid, 1);
    end
  endtask

  task automatic rd(input logic [2:0] op, input logic [7:0] a, input logic [1:0] b, input logic [7:0] ed, input logic ee);
    exp_q.push_back({ee, ed});
    acc_go(op, a, 8'h00, b);
    due_check();
  endtask

  task automatic reg_wr(input logic [1:0] b, input logic [2:0] r, input logic [7:0] d);
    mdl[{b, r}] = d;
    acc_go(3'd1, {5'd0, r}, d, b);
  endtask

  task automatic push(input logic [7:0] d);
    exp_sp = exp_sp + 8'd1;
    if (!exp_sp[7]) mdl[exp_sp[6:0]] = d;
    stk_go(1'b0, d);
  endtask

  task automatic pop_chk(input string tag);
    if (exp_sp[7]) exp_q.push_back(9'h100);
    else exp_q.push_back({1'b0, mdl[exp_sp[6:0]]});
    stk_go(1'b1, 8'h00);
    due_check();
    exp_sp = exp_sp - 8'd1;
    check(sp == exp_sp, tag, sp, exp_sp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(sp == 8'h07, "R1 reset pointer", sp, 8'h07);
    check(sp_ovf == 1'b0, "R1 reset overflow", sp_ovf, 0);
    check(rsp_valid == 1'b0, "R1 reset response", rsp_valid, 0);
    check(!sfr_we && !sfr_re, "R1 reset SFR strobes", {sfr_we, sfr_re}, 0);

    // R2: fill all four banks, read back by register form
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 8; r++)
        reg_wr(2'(b), 3'(r), 8'(b * 16 + r * 3 + 8'h21));
    for (int b = 3; b >= 0; b--)
      for (int r = 0; r < 8; r++)
        rd(3'd0, {5'b10101, 3'(r)}, 2'(b), mdl[{2'(b), 3'(r)}], 1'b0);

    // R3: direct reads alias the register bytes
    for (int a = 0; a < 32; a += 5)
      rd(3'd2, 8'(a), 2'd0, mdl[a], 1'b0);

    // R3/R5: direct writes, indirect reads, and back
    for (int i = 0; i < 4; i++) begin
      mdl[8'h40 + i] = 8'(8'h90 + i);
      acc_go(3'd3, 8'(8'h40 + i), 8'(8'h90 + i), 2'd0);
    end
    for (int i = 0; i < 4; i++) rd(3'd4, 8'(8'h40 + i), 2'd0, mdl[8'h40 + i], 1'b0);
    mdl[8'h55] = 8'hE7;
    acc_go(3'd5, 8'h55, 8'hE7, 2'd0);
    rd(3'd2, 8'h55, 2'd0, 8'hE7, 1'b0);
    check(sfr_wr_cnt == 0 && sfr_rd_cnt == 0, "R3 no SFR strobe for low direct", sfr_wr_cnt, 0);

    // R4: high direct addresses go to SFR port
    acc_go(3'd3, 8'h90, 8'h77, 2'd1);
    @(negedge clk);
    check(sfr_wr_cnt == 1, "R4 SFR write count", sfr_wr_cnt, 1);
    check(sfr_last_a == 8'h90 && sfr_last_d == 8'h77, "R4 SFR write fields", {sfr_last_a, sfr_last_d}, 16'h9077);
    rd(3'd2, 8'h10, 2'd0, mdl[8'h10], 1'b0);
    rd(3'd2, 8'hA5, 2'd0, 8'hA5 ^ 8'h3C, 1'b0);
    check(sfr_rd_cnt == 1, "R4 SFR read count", sfr_rd_cnt, 1);

    // R5: refused pointers
    acc_go(3'd5, 8'h90, 8'h11, 2'd0);
    @(negedge clk);
    check(sfr_wr_cnt == 1, "R5 refused write no SFR", sfr_wr_cnt, 1);
    rd(3'd2, 8'h10, 2'd0, mdl[8'h10], 1'b0);
    rd(3'd4, 8'hC0, 2'd0, 8'h00, 1'b1);
    check(sfr_rd_cnt == 1, "R5 refused read no SFR", sfr_rd_cnt, 1);

    // R7/R8: pop down through zero and wrap
    for (int i = 0; i < 8; i++) pop_chk("R7 pop pointer");
    check(sp == 8'hFF, "R8 wrap to FFh", sp, 8'hFF);
    push(8'h5C);
    @(negedge clk);
    check(sp == 8'h00 && sp_ovf == 1'b0, "R8 wrap push no overflow", {sp_ovf, sp}, 0);
    rd(3'd0, 8'h00, 2'd0, 8'h5C, 1'b0); // R6 data at new pointer

    // R9: simultaneous push and register write
    @(negedge clk);
    stk_valid = 1'b1; stk_pop = 1'b0; stk_wdata = 8'h66;
    acc_valid = 1'b1; acc_op = 3'd1; acc_addr = 8'h01; acc_wdata = 8'h99; bank_sel = 2'd0;
    #1;
    check(stk_ready && !acc_ready, "R9 stack granted first", {stk_ready, acc_ready}, 2'b10);
    @(posedge clk); #1 stk_valid = 1'b0;
    @(negedge clk); #1;
    check(acc_ready == 1'b1, "R9 access granted next", acc_ready, 1);
    @(posedge clk); #1 acc_valid = 1'b0;
    exp_sp = 8'h01; mdl[1] = 8'h99;
    pop_chk("R9 pop after ordered writes");

    // R6/R8: fill to 7Fh then overflow
    for (int i = 0; i < 127; i++) push(8'(i * 7 + 3));
    @(negedge clk);
    check(sp == 8'h7F && !sp_ovf, "R6 pointer at top", {sp_ovf, sp}, 8'h7F);
    push(8'hEE);
    @(negedge clk);
    check(sp == 8'h80 && sp_ovf, "R8 overflow set", {sp_ovf, sp}, 9'h180);
    rd(3'd2, 8'h00, 2'd0, mdl[0], 1'b0); // R8 dropped write did not alias
    pop_chk("R8 pop at 80h");
    pop_chk("R7 pop after overflow");
    check(sp_ovf == 1'b1, "R8 overflow sticky", sp_ovf, 1);

    // R10: back-pressure
    bp_mode = 1'b1;
    for (int i = 0; i < 12; i++)
      rd(3'd0, 8'(i), 2'(i % 4), mdl[{2'(i % 4), 3'(i)}], 1'b0);
    pop_chk("R10 pop under back-pressure");
    repeat (10) @(posedge clk);
    bp_mode = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R10 all responses delivered", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule